// File: doc/BRIEF.md
# Logarithmic Approximate Multiplier

This block multiplies two unsigned operands approximately. It does not build a partial-product array. Each operand is turned into a base-2 logarithm: the position of its leading one is the integer part, and the bits below that leading one, moved to the top of a fixed-point fraction, are the fractional part. The two logarithms are added. The sum is then turned back into a product by placing a single one at the bit position given by the summed integer part and laying the summed fraction bits directly below it. The result never exceeds the true product, and it falls short by at most about one ninth of it. This suits signal-processing and neural-network datapaths that tolerate a small, one-sided error in exchange for far less logic.

The operand width is a parameter. It is meant for values from 8 to 16 bits, and the product is twice as wide. The datapath has one register stage. A request presented with `in_valid` high on one clock edge shows its product, with `out_valid` high, after that edge. When `in_valid` is low, the product register keeps its previous contents. A synchronous active-high reset clears both the product and the valid flag.

Top module: `mitch_mul`

## Requirements
- R1: If either operand is zero when `in_valid` is high, the product registered on that edge is zero.
- R2: For nonzero operands a and b, let ka and kb be the positions of their leading ones, and let ra = a - 2^ka and rb = b - 2^kb. Let s = ra·2^kb + rb·2^ka and t = 2^(ka+kb). The product is t + s when s < t, and 2t + 2(s - t) otherwise.
- R3: With 8-bit operands, 234 × 198 yields 45056, because the fraction sum carries into the integer part and lifts it to 15. 255 × 255 yields 65024.
- R4: The product never exceeds the exact product a·b.
- R5: For nonzero operands, nine times the shortfall (a·b - product) is at most a·b, so the relative error stays within about 11.1 percent.
- R6: `out_valid` equals the value `in_valid` had on the previous clock edge.
- R7: When `in_valid` is low, `product` keeps its value on the following edge, whatever the operands are.
- R8: While `rst` is high on a clock edge, `out_valid` and `product` are zero after that edge.
- R9: Over all pairs of nonzero 8-bit operands, the mean relative error is below 4.5 percent.
- R10: Swapping the two operands does not change the product.
- R11: When both operands are powers of two, the product is exact and has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are presented and are to be multiplied |
| op_a | input | N | First unsigned operand |
| op_b | input | N | Second unsigned operand |
| out_valid | output | 1 | `product` holds a result registered on the previous edge |
| product | output | 2N | Approximate unsigned product |

## Verification
There is one register between the operands and `product`, so a fault in the leading-one detector, the logarithm adder or the shifter shows at the ports one cycle after the operands that expose it. A mis-detected leading one moves the product by a power of two. A lost fraction carry leaves the product about half its proper size. Either fault breaks the upper or lower error bound at once. Comparing every 8-bit operand pair, and random 16-bit pairs, against the closed-form value of R2 catches single-bit faults in the fraction placement that the error bounds alone would miss. Faults in the valid pipeline or in the hold behaviour show as a product that changes while `in_valid` was low, or as an `out_valid` that lags or leads by a cycle.

// File: rtl/mitch_pkg.sv
package mitch_pkg;

    // Bits needed for the leading-one position of an n-bit operand.
    function automatic int chr_width(input int n);
        return $clog2(n);
    endfunction

    // Bits needed for the summed integer part, including the fraction carry.
    function automatic int sum_width(input int n);
        return $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/mitch_lod.sv
module mitch_lod #(
    parameter int N = 8
) (
    input  logic [N-1:0]                          val,
    output logic [mitch_pkg::chr_width(N)-1:0]    chr,
    output logic [N-2:0]                          frac
);
    localparam int KW = mitch_pkg::chr_width(N);
    localparam int F  = N - 1;
    localparam logic [KW-1:0] TOP = KW'(N - 1);

    logic [KW-1:0] sh;

    // Priority encoder: the highest set bit wins.
    always_comb begin
        chr = '0;
        for (int i = 0; i < N; i++) begin
            if (val[i]) chr = i[KW-1:0];
        end
    end

    // Normalise: move the bits below the leading one to the top of the fraction.
    assign sh   = TOP - chr;
    assign frac = val[F-1:0] << sh;

endmodule

// File: rtl/mitch_logadd.sv
module mitch_logadd #(
    parameter int N = 8
) (
    input  logic [mitch_pkg::chr_width(N)-1:0] chr_a,
    input  logic [N-2:0]                       frac_a,
    input  logic [mitch_pkg::chr_width(N)-1:0] chr_b,
    input  logic [N-2:0]                       frac_b,
    output logic [mitch_pkg::sum_width(N)-1:0] sum_chr,
    output logic [N-2:0]                       sum_frac
);
    localparam int KW = mitch_pkg::chr_width(N);
    localparam int SW = mitch_pkg::sum_width(N);
    localparam int F  = N - 1;

    logic [F:0] fsum;

    // Fraction sum; its carry feeds the integer part.
    assign fsum     = {1'b0, frac_a} + {1'b0, frac_b};
    assign sum_frac = fsum[F-1:0];
    assign sum_chr  = SW'(chr_a) + SW'(chr_b) + SW'(fsum[F]);

endmodule

// File: rtl/mitch_antilog.sv
module mitch_antilog #(
    parameter int N = 8
) (
    input  logic [mitch_pkg::sum_width(N)-1:0] sum_chr,
    input  logic [N-2:0]                       sum_frac,
    output logic [2*N-1:0]                     prod
);
    localparam int SW = mitch_pkg::sum_width(N);
    localparam int F  = N - 1;
    localparam int PW = 2 * N;
    localparam logic [SW-1:0] FW = SW'(F);

    logic [PW-1:0] lead;
    logic [PW-1:0] tail;
    logic [PW-1:0] fext;

    assign fext = {{(PW-F){1'b0}}, sum_frac};
    assign lead = {{(PW-1){1'b0}}, 1'b1} << sum_chr;

    // Fraction placed directly below the inserted one. When the integer part
    // is narrower than the fraction, the low bits drop off (truncation).
    always_comb begin
        if (sum_chr >= FW) tail = fext << (sum_chr - FW);
        else               tail = fext >> (FW - sum_chr);
    end

    assign prod = lead | tail;

endmodule

// File: rtl/mitch_mul.sv
module mitch_mul #(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [N-1:0]     op_a,
    input  logic [N-1:0]     op_b,
    output logic             out_valid,
    output logic [2*N-1:0]   product
);
    localparam int KW = mitch_pkg::chr_width(N);
    localparam int SW = mitch_pkg::sum_width(N);
    localparam int F  = N - 1;

    logic [KW-1:0]  chr_a, chr_b;
    logic [F-1:0]   frac_a, frac_b;
    logic [SW-1:0]  sum_chr;
    logic [F-1:0]   sum_frac;
    logic [2*N-1:0] approx;
    logic           any_zero;
    logic [2*N-1:0] next_prod;

    mitch_lod #(.N(N)) u_lod_a (.val(op_a), .chr(chr_a), .frac(frac_a));
    mitch_lod #(.N(N)) u_lod_b (.val(op_b), .chr(chr_b), .frac(frac_b));

    mitch_logadd #(.N(N)) u_add (
        .chr_a(chr_a), .frac_a(frac_a),
        .chr_b(chr_b), .frac_b(frac_b),
        .sum_chr(sum_chr), .sum_frac(sum_frac)
    );

    mitch_antilog #(.N(N)) u_alog (
        .sum_chr(sum_chr), .sum_frac(sum_frac), .prod(approx)
    );

    // Zero detector overrides the logarithmic path.
    assign any_zero  = (op_a == '0) || (op_b == '0);
    assign next_prod = any_zero ? '0 : approx;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) product <= next_prod;
        end
    end

endmodule

// File: rtl/mitch_mul_chk.sv
module mitch_mul_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic           out_valid,
    input logic [2*N-1:0] product
);
    logic [2*N-1:0] exact_c;
    logic [2*N-1:0] exact_q;
    logic [2*N+3:0] gap9;

    assign exact_c = {{N{1'b0}}, op_a} * {{N{1'b0}}, op_b};

    always_ff @(posedge clk) exact_q <= exact_c;

    assign gap9 = ({4'b0, exact_q} - {4'b0, product}) * (2*N+4)'(9);

    assert_zero_forced_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid && (op_a == '0 || op_b == '0) |=> product == '0);

    assert_no_overshoot_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> product <= exact_q);

    assert_error_bound_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_a != '0 && op_b != '0 |=> gap9 <= {4'b0, exact_q});

    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_fall_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(product));

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> !out_valid && product == '0);

    assert_pow2_exact_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid && $countones(op_a) == 1 && $countones(op_b) == 1
        |=> $countones(product) == 1 && product == exact_q);

endmodule

bind mitch_mul mitch_mul_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product)
);

// File: tb/mitch_mul_test.sv
module mitch_mul_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        v8 = 1'b0, v16 = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] a16 = '0, b16 = '0;
    logic        ov8, ov16;
    logic [15:0] p8;
    logic [31:0] p16;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    longint hold8 = 0, hold16 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mitch_mul #(.N(8)) uut (
        .clk(clk), .rst(rst), .in_valid(v8), .op_a(a8), .op_b(b8),
        .out_valid(ov8), .product(p8)
    );

    mitch_mul #(.N(16)) uut16 (
        .clk(clk), .rst(rst), .in_valid(v16), .op_a(a16), .op_b(b16),
        .out_valid(ov16), .product(p16)
    );

    function automatic int msb_pos(input longint x);
        int p = 0;
        for (int i = 0; i < 40; i++) if (x >= (longint'(1) << i)) p = i;
        return p;
    endfunction

    // Closed form of R2; zero operands give zero (R1).
    function automatic longint ref_mul(input longint a, input longint b);
        int ka, kb;
        longint ra, rb, s, t;
        if (a == 0 || b == 0) return 0;
        ka = msb_pos(a);
        kb = msb_pos(b);
        ra = a - (longint'(1) << ka);
        rb = b - (longint'(1) << kb);
        s  = (ra << kb) + (rb << ka);
        t  = longint'(1) << (ka + kb);
        if (s < t) return t + s;
        return 2 * t + 2 * (s - t);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bounds(input string w, input longint a, input longint b, input longint p);
        longint e = a * b;
        if (a != 0 && b != 0) begin
            chk(p <= e, {"R4 ", w}, p, e);
            chk(9 * (e - p) <= e, {"R5 ", w}, p, e);
        end
    endtask

    // One cycle: drive at a falling edge, check at the next falling edge.
    task automatic step(input logic va, input logic [7:0] x8, input logic [7:0] y8,
                        input logic vb, input logic [15:0] x16, input logic [15:0] y16,
                        output longint g8, output longint g16);
        longint e8, e16;
        v8 = va; a8 = x8; b8 = y8;
        v16 = vb; a16 = x16; b16 = y16;
        e8  = va ? ref_mul(x8, y8)   : hold8;
        e16 = vb ? ref_mul(x16, y16) : hold16;
        @(negedge clk);
        g8 = p8;
        g16 = p16;
        chk(ov8 == va, "R6 n8", ov8, va);
        chk(ov16 == vb, "R6 n16", ov16, vb);
        chk(g8 == e8, va ? "R2 n8" : "R7 n8", g8, e8);
        chk(g16 == e16, vb ? "R2 n16" : "R7 n16", g16, e16);
        if (va) bounds("n8", x8, y8, g8);
        if (vb) bounds("n16", x16, y16, g16);
        hold8 = g8;
        hold16 = g16;
    endtask

    initial begin
        longint g8, g16, h8, h16;
        real esum = 0.0;
        int  ecnt = 0;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        chk(ov8 == 1'b0 && p8 == 0, "R8 n8", p8, 0);
        chk(ov16 == 1'b0 && p16 == 0, "R8 n16", p16, 0);
        rst = 1'b0;

        // Directed corners.
        step(1, 8'd234, 8'd198, 1, 16'd0, 16'd4321, g8, g16);
        chk(g8 == 45056, "R3 234x198", g8, 45056);
        chk(g16 == 0, "R1 n16", g16, 0);
        step(1, 8'd0, 8'd77, 1, 16'd65535, 16'd65535, g8, g16);
        chk(g8 == 0, "R1 n8", g8, 0);
        step(1, 8'd255, 8'd255, 1, 16'd512, 16'd64, g8, g16);
        chk(g8 == 65024, "R3 255x255", g8, 65024);
        chk(g16 == 32768, "R11 n16", g16, 32768);
        step(1, 8'd128, 8'd64, 1, 16'd1, 16'd1, g8, g16);
        chk(g8 == 8192 && $countones(g8) == 1, "R11 n8", g8, 8192);
        step(1, 8'd255, 8'd0, 1, 16'd4321, 16'd0, g8, g16);
        chk(g8 == 0 && g16 == 0, "R1 both", g8 + g16, 0);

        // Hold while in_valid is low, with changing operands (R7).
        step(1, 8'd200, 8'd3, 1, 16'd1000, 16'd999, g8, g16);
        h8 = g8; h16 = g16;
        for (int i = 0; i < 4; i++) begin
            step(0, 8'($urandom), 8'($urandom), 0, 16'($urandom), 16'($urandom), g8, g16);
            chk(g8 == h8 && g16 == h16, "R7 hold", g8, h8);
        end

        // Operand swap (R10).
        for (int i = 0; i < 200; i++) begin
            logic [7:0]  x = 8'($urandom), y = 8'($urandom);
            logic [15:0] u = 16'($urandom), w = 16'($urandom);
            step(1, x, y, 1, u, w, g8, g16);
            step(1, y, x, 1, w, u, h8, h16);
            chk(g8 == h8, "R10 n8", h8, g8);
            chk(g16 == h16, "R10 n16", h16, g16);
        end

        // All 8-bit pairs with random 16-bit pairs alongside; occasional idle cycles.
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                step(1, 8'(a), 8'(b), ($urandom % 8) != 0, 16'($urandom), 16'($urandom), g8, g16);
                if (a != 0 && b != 0) begin
                    esum += real'(a * b - g8) / real'(a * b);
                    ecnt++;
                end
            end
        end
        chk(esum * 100.0 / ecnt < 4.5, "R9 mean error x1000", longint'(esum * 100000.0 / ecnt), 4500);

        // Reset in mid-operation (R8).
        rst = 1'b1;
        @(negedge clk);
        chk(ov8 == 1'b0 && p8 == 0, "R8 mid n8", p8, 0);
        chk(ov16 == 1'b0 && p16 == 0, "R8 mid n16", p16, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule